// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Controller

This block is the host end of a single-wire, open-drain bus with a pull-up resistor. It creates every waveform the host needs at the bit level: the long reset pulse and the listening window for a device's presence reply, and the write-one, write-zero and read time slots. The block never drives the line high. It only switches a pull-down enable, and it watches the line through a two-flop synchroniser.

A client issues one command at a time over a valid/ready handshake. The commands are: bus reset, write a bit, read a bit, write a byte and read a byte. When a command completes, the block pulses `done` for one cycle. The read result appears on `rsp_data`, and the error flag appears on `bus_err`. The presence result is held on `presence` until the next bus reset.

All timing is given in microseconds and converted to clock cycles through `CYC_PER_US`. A parameter switches every window to the overdrive set of values. Before each write or read slot, the block checks that the line has returned high. If the line is still low, the block refuses to start the slot and reports a stuck bus.

Top module: `swire_host`

## Requirements
- R1: After reset `line_pull` is 0, `cmd_ready` is 1, and `done`, `bus_err` and `presence` are all 0.
- R2: A reset command (`cmd_op` = 0) pulls the line low for exactly 480 us. It then keeps the line released for at least 480 us before `done`. `presence` becomes 1 only if the line is low 70 us after the release.
- R3: A write-bit command (`cmd_op` = 1) with `cmd_data[0]` = 1 pulls the line low for exactly 6 us. The line is therefore free again well inside 15 us of the falling edge.
- R4: A write-bit command with `cmd_data[0]` = 0 holds the line low for the whole 70 us slot.
- R5: Between the end of one slot's low phase and the next slot's falling edge, the line stays released for at least 1 us (the recovery time).
- R6: A read-bit command (`cmd_op` = 2) pulls the line low for exactly 6 us and samples the line 15 us after the fall. `rsp_data` is then {7'b0, sampled level}, where high reads as 1.
- R7: Byte commands run eight slots, least significant bit first. For a write byte (`cmd_op` = 3), bit i of `cmd_data` sets slot i's low width (6 us for 1, 70 us for 0). For a read byte (`cmd_op` = 4), slot i's sample becomes bit i of `rsp_data`.
- R8: `done` is high for exactly one cycle per command, and `cmd_ready` is low from acceptance until after `done`.
- R9: If the synchronised line is low when a write or read slot is about to start, no pull-down occurs. The command then ends with `done` and `bus_err` = 1, and a byte command skips its remaining slots. A command that completes normally reports `bus_err` = 0.
- R10: `presence` keeps its value across bit and byte commands and changes only on a reset command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command accepted when valid is high |
| cmd_op | input | 3 | 0 reset, 1 write bit, 2 read bit, 3 write byte, 4 read byte |
| cmd_data | input | 8 | Write data (bit 0 for single-bit write) |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Read result, valid with done |
| bus_err | output | 1 | Stuck-low bus detected, valid with done |
| presence | output | 1 | Device answered the last bus reset |
| line_pull | output | 1 | Enable of the open-drain pull-down |
| line_in | input | 1 | Line level (asynchronous) |

## Verification
The bench measures the exact low width of every pulse and the shortest released gap between slots in a byte. A design that confused the write-one and write-zero widths, or that started a new slot in the same cycle the previous one ended, would show a wrong width or a gap under 1 us.

A device model answers a bus reset with a presence pulse and answers read slots with a chosen bit pattern. An off-by-one sample point would miss the presence reply or misread a bit, and a reversed shift direction would return a mirrored byte.

Holding the line low before a command checks that no pull-down is emitted and that the error ends the byte early. A design that ignored the pre-slot check would drive the line and report success instead.

// File: rtl/swire_pkg.sv
package swire_pkg;

    typedef enum logic [2:0] {
        OP_RESET = 3'd0,
        OP_WBIT  = 3'd1,
        OP_RBIT  = 3'd2,
        OP_WBYTE = 3'd3,
        OP_RBYTE = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        SK_RST = 2'd0,
        SK_W0  = 2'd1,
        SK_W1  = 2'd2,
        SK_RD  = 2'd3
    } slot_e;

    typedef enum logic {
        ENG_IDLE   = 1'b0,
        ENG_ACTIVE = 1'b1
    } eng_st_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_st_e;

endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    // idle line level is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/swire_slot_engine.sv
module swire_slot_engine
    import swire_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 125,
    parameter bit          OVERDRIVE  = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  slot_e kind_i,
    input  logic  line_s,
    output logic  pull,
    output logic  fin,
    output logic  stuck,
    output logic  smp
);
    // window lengths in microseconds, per speed
    localparam int unsigned RSTL_US  = OVERDRIVE ? 48 : 480;
    localparam int unsigned RSTH_US  = OVERDRIVE ? 48 : 480;
    localparam int unsigned PRES_US  = OVERDRIVE ? 8  : 70;
    localparam int unsigned SLOT_US  = OVERDRIVE ? 10 : 70;
    localparam int unsigned W1LO_US  = OVERDRIVE ? 1  : 6;
    localparam int unsigned RDLO_US  = OVERDRIVE ? 1  : 6;
    localparam int unsigned RDSMP_US = OVERDRIVE ? 2  : 15;
    localparam int unsigned REC_US   = 1;

    localparam int unsigned RSTL_C  = RSTL_US  * CYC_PER_US;
    localparam int unsigned RSTH_C  = RSTH_US  * CYC_PER_US;
    localparam int unsigned PRES_C  = PRES_US  * CYC_PER_US;
    localparam int unsigned SLOT_C  = SLOT_US  * CYC_PER_US;
    localparam int unsigned W1LO_C  = W1LO_US  * CYC_PER_US;
    localparam int unsigned RDLO_C  = RDLO_US  * CYC_PER_US;
    localparam int unsigned RDSMP_C = RDSMP_US * CYC_PER_US;
    localparam int unsigned REC_C   = REC_US   * CYC_PER_US;

    localparam int unsigned END_RST = RSTL_C + RSTH_C + REC_C - 1;
    localparam int unsigned END_BIT = SLOT_C + REC_C - 1;
    localparam int unsigned CNT_W   = $clog2(END_RST + 1);

    localparam logic [CNT_W-1:0] K_LO_RST  = CNT_W'(RSTL_C - 1);
    localparam logic [CNT_W-1:0] K_LO_W0   = CNT_W'(SLOT_C - 1);
    localparam logic [CNT_W-1:0] K_LO_W1   = CNT_W'(W1LO_C - 1);
    localparam logic [CNT_W-1:0] K_LO_RD   = CNT_W'(RDLO_C - 1);
    localparam logic [CNT_W-1:0] K_SMP_RST = CNT_W'(RSTL_C + PRES_C);
    localparam logic [CNT_W-1:0] K_SMP_RD  = CNT_W'(RDSMP_C);
    localparam logic [CNT_W-1:0] K_END_RST = CNT_W'(END_RST);
    localparam logic [CNT_W-1:0] K_END_BIT = CNT_W'(END_BIT);
    localparam logic [CNT_W-1:0] K_REL_BIT = CNT_W'(SLOT_C);

    typedef struct packed {
        eng_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic             pull;
        logic             fin;
        logic             stuck;
        logic             smp;
        slot_e            kind;
    } eng_t;

    eng_t q, d;
    logic [CNT_W-1:0] lo_last, smp_at, end_at;
    logic             smp_en;

    // per-slot window table
    always_comb begin
        unique case (q.kind)
            SK_RST: begin lo_last = K_LO_RST; smp_at = K_SMP_RST; end_at = K_END_RST; smp_en = 1'b1; end
            SK_W0:  begin lo_last = K_LO_W0;  smp_at = '0;        end_at = K_END_BIT; smp_en = 1'b0; end
            SK_W1:  begin lo_last = K_LO_W1;  smp_at = '0;        end_at = K_END_BIT; smp_en = 1'b0; end
            default: begin lo_last = K_LO_RD; smp_at = K_SMP_RD;  end_at = K_END_BIT; smp_en = 1'b1; end
        endcase
    end

    always_comb begin
        d       = q;
        d.fin   = 1'b0;
        d.stuck = 1'b0;
        unique case (q.st)
            ENG_IDLE: begin
                if (start) begin
                    if (kind_i != SK_RST && !line_s) begin
                        // line not back high: refuse the slot
                        d.fin   = 1'b1;
                        d.stuck = 1'b1;
                    end else begin
                        d.st   = ENG_ACTIVE;
                        d.cnt  = '0;
                        d.pull = 1'b1;
                        d.kind = kind_i;
                    end
                end
            end
            default: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == lo_last) d.pull = 1'b0;
                if (smp_en && q.cnt == smp_at) d.smp = line_s;
                if (q.cnt == end_at) begin
                    d.st  = ENG_IDLE;
                    d.cnt = '0;
                    d.fin = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ENG_IDLE, cnt: '0, pull: 1'b0, fin: 1'b0,
                   stuck: 1'b0, smp: 1'b1, kind: SK_RST};
        end else begin
            q <= d;
        end
    end

    assign pull  = q.pull;
    assign fin   = q.fin;
    assign stuck = q.stuck;
    assign smp   = q.smp;

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ENG_IDLE) |-> !q.pull);

    assert_stuck_no_pull_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ENG_IDLE && start && kind_i != SK_RST && !line_s) |=> (!q.pull && q.stuck));

    assert_recovery_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ENG_ACTIVE && q.kind != SK_RST && q.cnt >= K_REL_BIT) |-> !q.pull);

    assert_start_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (q.st == ENG_IDLE));

    assert_fin_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.fin |=> !q.fin);
endmodule

// File: rtl/swire_byte_seq.sv
module swire_byte_seq
    import swire_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [2:0] cmd_op,
    input  logic [7:0] cmd_data,
    input  logic       eng_fin,
    input  logic       eng_stuck,
    input  logic       eng_smp,
    output logic       eng_start,
    output slot_e      eng_kind,
    output logic       done,
    output logic [7:0] rsp_data,
    output logic       bus_err,
    output logic       presence
);
    typedef struct packed {
        seq_st_e    st;
        op_e        op;
        logic [7:0] shreg;
        logic [2:0] bitcnt;
        logic       start;
        slot_e      kind;
        logic       done;
        logic [7:0] rsp;
        logic       err;
        logic       pres;
    } seq_t;

    seq_t q, d;
    logic [7:0] rd_shift;

    function automatic slot_e wr_kind(input logic b);
        return b ? SK_W1 : SK_W0;
    endfunction

    assign rd_shift = {eng_smp, q.shreg[7:1]};

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.done  = 1'b0;
        unique case (q.st)
            SEQ_IDLE: begin
                if (cmd_valid) begin
                    d.op     = op_e'(cmd_op);
                    d.shreg  = cmd_data;
                    d.bitcnt = '0;
                    d.st     = SEQ_WAIT;
                    d.start  = 1'b1;
                    unique case (op_e'(cmd_op))
                        OP_RESET:          d.kind = SK_RST;
                        OP_WBIT, OP_WBYTE: d.kind = wr_kind(cmd_data[0]);
                        OP_RBIT, OP_RBYTE: d.kind = SK_RD;
                        default: begin
                            // unknown code: complete without a slot
                            d.st    = SEQ_IDLE;
                            d.start = 1'b0;
                            d.done  = 1'b1;
                            d.err   = 1'b0;
                            d.rsp   = '0;
                        end
                    endcase
                end
            end
            default: begin
                if (eng_fin) begin
                    if (eng_stuck) begin
                        d.st   = SEQ_IDLE;
                        d.done = 1'b1;
                        d.err  = 1'b1;
                        d.rsp  = '0;
                    end else begin
                        d.err = 1'b0;
                        unique case (q.op)
                            OP_RESET: begin
                                d.pres = !eng_smp;
                                d.rsp  = '0;
                                d.st   = SEQ_IDLE;
                                d.done = 1'b1;
                            end
                            OP_RBIT: begin
                                d.rsp  = {7'b0, eng_smp};
                                d.st   = SEQ_IDLE;
                                d.done = 1'b1;
                            end
                            OP_WBYTE: begin
                                if (q.bitcnt == 3'd7) begin
                                    d.rsp  = '0;
                                    d.st   = SEQ_IDLE;
                                    d.done = 1'b1;
                                end else begin
                                    d.shreg  = {1'b0, q.shreg[7:1]};
                                    d.bitcnt = q.bitcnt + 3'd1;
                                    d.kind   = wr_kind(q.shreg[1]);
                                    d.start  = 1'b1;
                                end
                            end
                            OP_RBYTE: begin
                                d.shreg = rd_shift;
                                if (q.bitcnt == 3'd7) begin
                                    d.rsp  = rd_shift;
                                    d.st   = SEQ_IDLE;
                                    d.done = 1'b1;
                                end else begin
                                    d.bitcnt = q.bitcnt + 3'd1;
                                    d.kind   = SK_RD;
                                    d.start  = 1'b1;
                                end
                            end
                            default: begin
                                d.rsp  = '0;
                                d.st   = SEQ_IDLE;
                                d.done = 1'b1;
                            end
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: SEQ_IDLE, op: OP_RESET, shreg: '0, bitcnt: '0,
                   start: 1'b0, kind: SK_RST, done: 1'b0, rsp: '0,
                   err: 1'b0, pres: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign cmd_ready = (q.st == SEQ_IDLE);
    assign eng_start = q.start;
    assign eng_kind  = q.kind;
    assign done      = q.done;
    assign rsp_data  = q.rsp;
    assign bus_err   = q.err;
    assign presence  = q.pres;

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid && cmd_op <= 3'd4) |=> !cmd_ready);

    assert_presence_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.op != OP_RESET) |=> $stable(q.pres));

    assert_bitcount_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SEQ_WAIT && (q.op == OP_WBIT || q.op == OP_RBIT || q.op == OP_RESET))
            |-> (q.bitcnt == 3'd0));
endmodule

// File: rtl/swire_host.sv
module swire_host
    import swire_pkg::*;
#(
    parameter int unsigned CYC_PER_US  = 125,
    parameter bit          OVERDRIVE   = 1'b0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [2:0] cmd_op,
    input  logic [7:0] cmd_data,
    output logic       done,
    output logic [7:0] rsp_data,
    output logic       bus_err,
    output logic       presence,
    output logic       line_pull,
    input  logic       line_in
);
    logic  line_s;
    logic  eng_start, eng_fin, eng_stuck, eng_smp;
    slot_e eng_kind;

    swire_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_in),
        .dout (line_s)
    );

    swire_byte_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready),
        .cmd_op   (cmd_op),
        .cmd_data (cmd_data),
        .eng_fin  (eng_fin),
        .eng_stuck(eng_stuck),
        .eng_smp  (eng_smp),
        .eng_start(eng_start),
        .eng_kind (eng_kind),
        .done     (done),
        .rsp_data (rsp_data),
        .bus_err  (bus_err),
        .presence (presence)
    );

    swire_slot_engine #(.CYC_PER_US(CYC_PER_US), .OVERDRIVE(OVERDRIVE)) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .kind_i(eng_kind),
        .line_s(line_s),
        .pull  (line_pull),
        .fin   (eng_fin),
        .stuck (eng_stuck),
        .smp   (eng_smp)
    );

    assert_err_only_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_err) |-> done);
endmodule

// File: tb/swire_host_tb.sv
module swire_host_tb;
    localparam int US = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [2:0] cmd_op = '0;
    logic [7:0] cmd_data = '0;
    logic       done;
    logic [7:0] rsp_data;
    logic       bus_err;
    logic       presence;
    logic       line_pull;
    logic       line_in;

    logic stuck_low = 1'b0;
    int   slave_hold = 0;
    int   pres_wait = 0;
    logic pres_mode = 1'b0;
    logic rd_mode = 1'b0;
    logic [7:0] rd_pat = '0;
    int   rd_idx = 0;

    int n_checks = 0;
    int n_fail = 0;

    logic pull_prev = 1'b0;
    int low_run = 0;
    int high_run = 0;
    int n_pulse = 0;
    int gap_min = 1000000;
    int widths [16];

    always #4 clk = ~clk;

    assign line_in = !(line_pull || stuck_low || (slave_hold != 0));

    swire_host #(.CYC_PER_US(US)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .done(done), .rsp_data(rsp_data),
        .bus_err(bus_err), .presence(presence), .line_pull(line_pull), .line_in(line_in)
    );

    // line monitor and device model, updated away from the active edge
    always @(negedge clk) begin
        if (slave_hold > 0) slave_hold = slave_hold - 1;
        if (pres_wait > 0) begin
            pres_wait = pres_wait - 1;
            if (pres_wait == 0) slave_hold = 120 * US;
        end
        if (line_pull && !pull_prev) begin
            if (n_pulse > 0 && high_run < gap_min) gap_min = high_run;
            if (rd_mode) begin
                if (!rd_pat[rd_idx]) slave_hold = 30 * US;
                rd_idx = (rd_idx + 1) % 8;
            end
            low_run = 1;
        end else if (line_pull) begin
            low_run = low_run + 1;
        end else if (pull_prev) begin
            if (n_pulse < 16) widths[n_pulse] = low_run;
            n_pulse = n_pulse + 1;
            high_run = 1;
            if (pres_mode) pres_wait = 30 * US;
        end else begin
            high_run = high_run + 1;
        end
        pull_prev = line_pull;
    end

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic clear_log();
        n_pulse = 0;
        gap_min = 1000000;
        rd_idx = 0;
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [7:0] dat,
                          output int lat, output logic [7:0] rsp, output logic err);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = op;
        cmd_data = dat;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R8 ready low while busy", int'(cmd_ready), 0);
        lat = 1;
        while (!done && lat < 60000) begin
            @(negedge clk);
            lat++;
        end
        rsp = rsp_data;
        err = bus_err;
        @(negedge clk);
        chk(done == 1'b0, "R8 done lasts one cycle", int'(done), 0);
        chk(cmd_ready == 1'b1, "R8 ready after done", int'(cmd_ready), 1);
    endtask

    task automatic t_reset_state();
        chk(line_pull == 1'b0, "R1 pull idle", int'(line_pull), 0);
        chk(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(bus_err == 1'b0, "R1 bus_err", int'(bus_err), 0);
        chk(presence == 1'b0, "R1 presence", int'(presence), 0);
    endtask

    task automatic t_bus_reset(input logic answer);
        int lat; logic [7:0] r; logic e;
        clear_log();
        pres_mode = answer;
        do_cmd(3'd0, 8'h00, lat, r, e);
        pres_mode = 1'b0;
        chk(n_pulse == 1, "R2 one reset pulse", n_pulse, 1);
        chk(widths[0] == 480 * US, "R2 reset low width", widths[0], 480 * US);
        chk(lat >= 960 * US, "R2 release window before done", lat, 960 * US);
        chk(presence == answer, "R2 presence result", int'(presence), int'(answer));
    endtask

    task automatic t_write_bit(input logic b);
        int lat; logic [7:0] r; logic e;
        clear_log();
        do_cmd(3'd1, {7'b0, b}, lat, r, e);
        chk(n_pulse == 1, b ? "R3 one slot" : "R4 one slot", n_pulse, 1);
        if (b) begin
            chk(widths[0] == 6 * US, "R3 write-1 low width", widths[0], 6 * US);
            chk(widths[0] <= 15 * US, "R3 released within 15 us", widths[0], 15 * US);
        end else begin
            chk(widths[0] == 70 * US, "R4 write-0 low width", widths[0], 70 * US);
        end
        chk(e == 1'b0, "R9 no error on clean slot", int'(e), 0);
    endtask

    task automatic t_read_bit(input logic b);
        int lat; logic [7:0] r; logic e;
        clear_log();
        rd_pat = {7'b0, b};
        rd_mode = 1'b1;
        do_cmd(3'd2, 8'h00, lat, r, e);
        rd_mode = 1'b0;
        chk(widths[0] == 6 * US, "R6 read low width", widths[0], 6 * US);
        chk(r == {7'b0, b}, "R6 read bit value", int'(r), int'(b));
    endtask

    task automatic t_write_byte(input logic [7:0] v);
        int lat; logic [7:0] r; logic e;
        clear_log();
        do_cmd(3'd3, v, lat, r, e);
        chk(n_pulse == 8, "R7 eight write slots", n_pulse, 8);
        for (int i = 0; i < 8; i++) begin
            int exp_w;
            exp_w = v[i] ? 6 * US : 70 * US;
            chk(widths[i] == exp_w, "R7 write slot width lsb first", widths[i], exp_w);
        end
        chk(gap_min >= 1 * US, "R5 recovery between slots", gap_min, 1 * US);
    endtask

    task automatic t_read_byte(input logic [7:0] v);
        int lat; logic [7:0] r; logic e;
        clear_log();
        rd_pat = v;
        rd_mode = 1'b1;
        do_cmd(3'd4, 8'h00, lat, r, e);
        rd_mode = 1'b0;
        chk(n_pulse == 8, "R7 eight read slots", n_pulse, 8);
        chk(r == v, "R7 read byte lsb first", int'(r), int'(v));
        chk(gap_min >= 1 * US, "R5 recovery between read slots", gap_min, 1 * US);
    endtask

    task automatic t_stuck(input logic [2:0] op);
        int lat; logic [7:0] r; logic e;
        stuck_low = 1'b1;
        repeat (6) @(negedge clk);
        clear_log();
        do_cmd(op, 8'h00, lat, r, e);
        chk(e == 1'b1, "R9 stuck flagged", int'(e), 1);
        chk(n_pulse == 0 && !line_pull, "R9 no pull on stuck bus", n_pulse, 0);
        chk(lat < 10, "R9 remaining slots skipped", lat, 10);
        stuck_low = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset_state();

        t_bus_reset(1'b0);
        t_bus_reset(1'b1);
        t_write_bit(1'b1);
        chk(presence == 1'b1, "R10 presence kept after write", int'(presence), 1);
        t_write_bit(1'b0);
        t_read_bit(1'b1);
        t_read_bit(1'b0);
        t_write_byte(8'hA5);
        t_write_byte(8'h0E);
        t_read_byte(8'h3C);
        t_read_byte(8'hB1);
        chk(presence == 1'b1, "R10 presence kept after bytes", int'(presence), 1);
        t_stuck(3'd1);
        t_stuck(3'd4);
        t_write_bit(1'b1);
        t_bus_reset(1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule